// File: doc/BRIEF.md
# Indexed-Colour Display Control Register File

This block is the control register file of an 8-bit indexed-colour display controller. A host reaches it through a simple 32-bit register bus. Each access is a single cycle, and read data comes back registered one cycle later. The block stores three things: a 256-entry RGB colour lookup table, a three-entry RGB cursor colour table and a 512-word cursor bitmap. It also holds the scalar settings: screen origin, cursor coordinates, mode word, active width and active height.

A pixel pipeline uses three dedicated combinational lookup ports, one for each table, so pixel lookups never contend with the bus. The mode word drives the pixel pipeline in three ways: it is decoded into a pixel-depth code, a forced-blank flag and a cursor-disable flag.

A frame-done pulse from the pipeline raises an interrupt, and any bus write lowers it. A write of any value to the soft-reset offset clears every stored setting and table. Writes to the video timing offsets are accepted and have no effect. The block has no streaming data path. Every pin is a plain control, status or lookup signal.

Top module: `fbctl_regs`

## Requirements
- R1: A write to byte offset 0x800..0xFFF stores entry (offset-0x800)>>3 of the colour table, with red = wdata[23:16], green = wdata[15:8] and blue = wdata[7:0]. `pal_rgb` returns {R,G,B} of entry `pal_idx` in the same cycle.
- R2: The cursor colour table occupies offsets 0x508..0x51F, with entry (offset-0x508)>>3 in the range 0..2. It stores wdata[23:0] and reads back as {8'h00, R, G, B}. `cur_rgb` returns entry `cur_sel`, or 0 when `cur_sel` is 3.
- R3: The cursor bitmap occupies offsets 0x1000..0x1FFF, with entry (offset-0x1000)>>3. It stores wdata[15:0] and reads back zero-extended. `cpat_word` returns entry `cpat_idx`.
- R4: A write to 0x118 sets `width_px` to wdata×4, truncated to 32 bits. A read of 0x118 returns `width_px`/4.
- R5: A write to 0x150 sets `height_px` to wdata/2. A read of 0x150 returns `height_px`×2.
- R6: A write to 0x300 stores the mode word, and a read of 0x300 returns it. Mode bits 22:20 map to `depth_code` as 0→1, 1→2, 2→4, 3→8, 4→15, 5→16 and 6,7→0. Bit 10 drives `blank_force` and bit 23 drives `cursor_off`.
- R7: A write to 0x400 sets `screen_top` and a write to 0x638 sets `cursor_xy`. Both offsets read back as 0.
- R8: A write of any data to 0x100000 clears, at the next edge, both tables, the bitmap, the mode word, origin, cursor coordinates, width and height.
- R9: `irq` rises the cycle after `frame_done` is high. It falls the cycle after any bus write, whatever the offset. A write wins over a simultaneous `frame_done`. Reset clears it.
- R10: `bus_rdata` is valid in the cycle after `bus_rd`. It is 0 in a cycle after `bus_rd` was low. A read that coincides with a write returns the value from before the write. The colour table and all offsets not listed above read as 0.
- R11: Writes to offsets 0x000, 0x108, 0x110, 0x120, 0x128, 0x130, 0x138, 0x140, 0x148, 0x158, 0x160, 0x168, 0x170 and 0x200 change no stored state, apart from lowering `irq`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 21 | Byte offset of the access |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | 32 | Write data |
| bus_rd | input | 1 | Read strobe |
| bus_rdata | output | 32 | Registered read data |
| frame_done | input | 1 | End-of-frame pulse from the pixel pipeline |
| irq | output | 1 | Frame interrupt |
| pal_idx | input | 8 | Colour table lookup index |
| pal_rgb | output | 24 | Colour table entry {R,G,B} |
| cur_sel | input | 2 | Cursor colour lookup index |
| cur_rgb | output | 24 | Cursor colour entry {R,G,B} |
| cpat_idx | input | 9 | Cursor bitmap lookup index |
| cpat_word | output | 16 | Cursor bitmap entry |
| depth_code | output | 5 | Pixel depth decoded from the mode word |
| blank_force | output | 1 | Force blanking |
| cursor_off | output | 1 | Cursor disabled |
| screen_top | output | 32 | Screen origin |
| cursor_xy | output | 32 | Cursor coordinates |
| width_px | output | 32 | Active width in pixels |
| height_px | output | 32 | Active height in lines |

## Verification
The hardest cases to produce from the ports involve collisions. One is a soft reset that arrives while the tables are full and a read is in flight in the same cycle. Another is a write that lands in the same cycle as `frame_done`. A third is a table access at an offset that is not a multiple of eight. A long random phase reaches these cases by mixing window offsets, including unaligned ones, with timing offsets, unmapped offsets and occasional soft resets. It drives random read, write and frame-done strobes together. A behavioural reference model, compared on every clock, shows that reads return pre-write data and that the interrupt favours the write.

// File: rtl/fbctl_pkg.sv
package fbctl_pkg;

  typedef enum logic [3:0] {
    RG_NONE, RG_CLUT, RG_CURCLR, RG_CURPAT, RG_HSIZE, RG_VSIZE,
    RG_MODE, RG_ORIGIN, RG_CURXY, RG_SRESET, RG_TIMING
  } region_e;

  localparam int unsigned CLUT_BASE   = 32'h0000_0800;
  localparam int unsigned CURCLR_BASE = 32'h0000_0508;
  localparam int unsigned CURPAT_BASE = 32'h0000_1000;
  localparam int unsigned OFS_HSIZE   = 32'h0000_0118;
  localparam int unsigned OFS_VSIZE   = 32'h0000_0150;
  localparam int unsigned OFS_MODE    = 32'h0000_0300;
  localparam int unsigned OFS_ORIGIN  = 32'h0000_0400;
  localparam int unsigned OFS_CURXY   = 32'h0000_0638;
  localparam int unsigned OFS_SRESET  = 32'h0010_0000;
  localparam int unsigned ENTRY_SHIFT = 3;

  function automatic logic [4:0] depth_of(input logic [2:0] sel);
    case (sel)
      3'd0:    return 5'd1;
      3'd1:    return 5'd2;
      3'd2:    return 5'd4;
      3'd3:    return 5'd8;
      3'd4:    return 5'd15;
      3'd5:    return 5'd16;
      default: return 5'd0;
    endcase
  endfunction

endpackage

// File: rtl/fbctl_decode.sv
module fbctl_decode
  import fbctl_pkg::*;
#(
  parameter int ADDR_W      = 21,
  parameter int IDX_W       = 9,
  parameter int CLUT_SPAN   = 2048,
  parameter int CURCLR_SPAN = 24,
  parameter int CURPAT_SPAN = 4096
) (
  input  logic [ADDR_W-1:0] addr,
  output region_e           region,
  output logic [IDX_W-1:0]  idx
);

  logic [ADDR_W-1:0] off;

  always_comb begin
    region = RG_NONE;
    off    = '0;
    if (addr >= ADDR_W'(CLUT_BASE) && addr < ADDR_W'(CLUT_BASE + CLUT_SPAN)) begin
      region = RG_CLUT;
      off    = addr - ADDR_W'(CLUT_BASE);
    end else if (addr >= ADDR_W'(CURPAT_BASE) && addr < ADDR_W'(CURPAT_BASE + CURPAT_SPAN)) begin
      region = RG_CURPAT;
      off    = addr - ADDR_W'(CURPAT_BASE);
    end else if (addr >= ADDR_W'(CURCLR_BASE) && addr < ADDR_W'(CURCLR_BASE + CURCLR_SPAN)) begin
      region = RG_CURCLR;
      off    = addr - ADDR_W'(CURCLR_BASE);
    end else begin
      case (addr)
        ADDR_W'(OFS_HSIZE):  region = RG_HSIZE;
        ADDR_W'(OFS_VSIZE):  region = RG_VSIZE;
        ADDR_W'(OFS_MODE):   region = RG_MODE;
        ADDR_W'(OFS_ORIGIN): region = RG_ORIGIN;
        ADDR_W'(OFS_CURXY):  region = RG_CURXY;
        ADDR_W'(OFS_SRESET): region = RG_SRESET;
        ADDR_W'(32'h000), ADDR_W'(32'h108), ADDR_W'(32'h110), ADDR_W'(32'h120),
        ADDR_W'(32'h128), ADDR_W'(32'h130), ADDR_W'(32'h138), ADDR_W'(32'h140),
        ADDR_W'(32'h148), ADDR_W'(32'h158), ADDR_W'(32'h160), ADDR_W'(32'h168),
        ADDR_W'(32'h170), ADDR_W'(32'h200): region = RG_TIMING;
        default: region = RG_NONE;
      endcase
    end
  end

  assign idx = IDX_W'(off >> ENTRY_SHIFT);

endmodule

// File: rtl/fbctl_table.sv
module fbctl_table #(
  parameter int DEPTH = 4,
  parameter int WIDTH = 8,
  parameter int AW    = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             we,
  input  logic [AW-1:0]    waddr,
  input  logic [WIDTH-1:0] wdata,
  input  logic [AW-1:0]    raddr_a,
  output logic [WIDTH-1:0] rdata_a,
  input  logic [AW-1:0]    raddr_b,
  output logic [WIDTH-1:0] rdata_b
);

  logic [WIDTH-1:0] mem [DEPTH];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else if (clr) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else if (we && int'(waddr) < DEPTH) begin
      mem[waddr] <= wdata;
    end
  end

  generate
    if (DEPTH == (1 << AW)) begin : g_full
      assign rdata_a = mem[raddr_a];
      assign rdata_b = mem[raddr_b];
    end else begin : g_part
      assign rdata_a = (int'(raddr_a) < DEPTH) ? mem[raddr_a] : '0;
      assign rdata_b = (int'(raddr_b) < DEPTH) ? mem[raddr_b] : '0;
    end
  endgenerate

endmodule

// File: rtl/fbctl_regs.sv
module fbctl_regs
  import fbctl_pkg::*;
#(
  parameter int ADDR_W       = 21,
  parameter int COLOR_W      = 8,
  parameter int CLUT_DEPTH   = 256,
  parameter int CUR_COLORS   = 3,
  parameter int CURPAT_DEPTH = 512,
  parameter int CURPAT_W     = 16
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [ADDR_W-1:0]    bus_addr,
  input  logic                 bus_wr,
  input  logic [31:0]          bus_wdata,
  input  logic                 bus_rd,
  output logic [31:0]          bus_rdata,
  input  logic                 frame_done,
  output logic                 irq,
  input  logic [$clog2(CLUT_DEPTH)-1:0]   pal_idx,
  output logic [3*COLOR_W-1:0] pal_rgb,
  input  logic [$clog2(CUR_COLORS)-1:0]   cur_sel,
  output logic [3*COLOR_W-1:0] cur_rgb,
  input  logic [$clog2(CURPAT_DEPTH)-1:0] cpat_idx,
  output logic [CURPAT_W-1:0]  cpat_word,
  output logic [4:0]           depth_code,
  output logic                 blank_force,
  output logic                 cursor_off,
  output logic [31:0]          screen_top,
  output logic [31:0]          cursor_xy,
  output logic [31:0]          width_px,
  output logic [31:0]          height_px
);

  localparam int RGB_W     = 3 * COLOR_W;
  localparam int CLUT_AW   = $clog2(CLUT_DEPTH);
  localparam int CURC_AW   = $clog2(CUR_COLORS);
  localparam int CURPAT_AW = $clog2(CURPAT_DEPTH);
  localparam int STRIDE    = 1 << ENTRY_SHIFT;

  region_e                dec_region;
  logic [CURPAT_AW-1:0]   dec_idx;
  logic                   soft_clr;
  logic [RGB_W-1:0]       clut_bus_unused;
  logic [RGB_W-1:0]       curc_bus;
  logic [CURPAT_W-1:0]    cpat_bus;
  logic [31:0]            mode_q, rd_val;

  fbctl_decode #(
    .ADDR_W(ADDR_W), .IDX_W(CURPAT_AW),
    .CLUT_SPAN(CLUT_DEPTH * STRIDE), .CURCLR_SPAN(CUR_COLORS * STRIDE),
    .CURPAT_SPAN(CURPAT_DEPTH * STRIDE)
  ) u_decode (
    .addr(bus_addr), .region(dec_region), .idx(dec_idx)
  );

  assign soft_clr = bus_wr && (dec_region == RG_SRESET);

  fbctl_table #(.DEPTH(CLUT_DEPTH), .WIDTH(RGB_W)) u_clut (
    .clk(clk), .rst_n(rst_n), .clr(soft_clr),
    .we(bus_wr && dec_region == RG_CLUT),
    .waddr(dec_idx[CLUT_AW-1:0]), .wdata(bus_wdata[RGB_W-1:0]),
    .raddr_a(dec_idx[CLUT_AW-1:0]), .rdata_a(clut_bus_unused),
    .raddr_b(pal_idx), .rdata_b(pal_rgb)
  );

  fbctl_table #(.DEPTH(CUR_COLORS), .WIDTH(RGB_W)) u_curclr (
    .clk(clk), .rst_n(rst_n), .clr(soft_clr),
    .we(bus_wr && dec_region == RG_CURCLR),
    .waddr(dec_idx[CURC_AW-1:0]), .wdata(bus_wdata[RGB_W-1:0]),
    .raddr_a(dec_idx[CURC_AW-1:0]), .rdata_a(curc_bus),
    .raddr_b(cur_sel), .rdata_b(cur_rgb)
  );

  fbctl_table #(.DEPTH(CURPAT_DEPTH), .WIDTH(CURPAT_W)) u_curpat (
    .clk(clk), .rst_n(rst_n), .clr(soft_clr),
    .we(bus_wr && dec_region == RG_CURPAT),
    .waddr(dec_idx), .wdata(bus_wdata[CURPAT_W-1:0]),
    .raddr_a(dec_idx), .rdata_a(cpat_bus),
    .raddr_b(cpat_idx), .rdata_b(cpat_word)
  );

  // Scalar settings; the soft reset takes priority over any field update.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= '0; screen_top <= '0; cursor_xy <= '0;
      width_px <= '0; height_px <= '0;
    end else if (soft_clr) begin
      mode_q <= '0; screen_top <= '0; cursor_xy <= '0;
      width_px <= '0; height_px <= '0;
    end else if (bus_wr) begin
      case (dec_region)
        RG_HSIZE:  width_px   <= {bus_wdata[29:0], 2'b00};
        RG_VSIZE:  height_px  <= {1'b0, bus_wdata[31:1]};
        RG_MODE:   mode_q     <= bus_wdata;
        RG_ORIGIN: screen_top <= bus_wdata;
        RG_CURXY:  cursor_xy  <= bus_wdata;
        default:   ;
      endcase
    end
  end

  // Readable locations; the colour table contents never reach the bus.
  always_comb begin
    case (dec_region)
      RG_CURCLR: rd_val = 32'(curc_bus);
      RG_CURPAT: rd_val = 32'(cpat_bus);
      RG_HSIZE:  rd_val = {2'b00, width_px[31:2]};
      RG_VSIZE:  rd_val = {height_px[30:0], 1'b0};
      RG_MODE:   rd_val = mode_q;
      default:   rd_val = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) bus_rdata <= '0;
    else        bus_rdata <= bus_rd ? rd_val : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          irq <= 1'b0;
    else if (bus_wr)     irq <= 1'b0;
    else if (frame_done) irq <= 1'b1;
  end

  assign depth_code  = depth_of(mode_q[22:20]);
  assign blank_force = mode_q[10];
  assign cursor_off  = mode_q[23];

endmodule

// File: rtl/fbctl_regs_chk.sv
module fbctl_regs_chk #(
  parameter int ADDR_W = 21
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              bus_wr,
  input logic [31:0]       bus_wdata,
  input logic              bus_rd,
  input logic [31:0]       bus_rdata,
  input logic              frame_done,
  input logic              irq,
  input logic [4:0]        depth_code,
  input logic              blank_force,
  input logic [31:0]       screen_top,
  input logic [31:0]       cursor_xy,
  input logic [31:0]       width_px,
  input logic [31:0]       height_px
);

  AST_IRQ_WR_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    bus_wr |=> !irq); // R9
  AST_IRQ_FRAME_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_done && !bus_wr) |=> irq); // R9
  AST_SRESET_ZEROES: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == ADDR_W'(32'h10_0000)) |=>
      (width_px == 0 && height_px == 0 && screen_top == 0 && cursor_xy == 0 && depth_code == 5'd1)); // R8
  AST_RDATA_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_rd |=> bus_rdata == 32'd0); // R10
  AST_WIDTH_SCALE: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == ADDR_W'(32'h118)) |=> width_px == ($past(bus_wdata) << 2)); // R4
  AST_HEIGHT_SCALE: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == ADDR_W'(32'h150)) |=> height_px == ($past(bus_wdata) >> 1)); // R5
  AST_MODE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_wr |=> ($stable(depth_code) && $stable(blank_force))); // R6
  AST_ORIGIN_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_wr |=> ($stable(screen_top) && $stable(cursor_xy))); // R7

endmodule

bind fbctl_regs fbctl_regs_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
  .bus_wdata(bus_wdata), .bus_rd(bus_rd), .bus_rdata(bus_rdata),
  .frame_done(frame_done), .irq(irq), .depth_code(depth_code),
  .blank_force(blank_force), .screen_top(screen_top), .cursor_xy(cursor_xy),
  .width_px(width_px), .height_px(height_px)
);

// File: tb/fbctl_regs_bench.sv
`timescale 1ns/1ps
module fbctl_regs_bench;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [20:0] bus_addr = '0;
  logic        bus_wr = 1'b0, bus_rd = 1'b0, frame_done = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        irq;
  logic [7:0]  pal_idx = '0;
  logic [1:0]  cur_sel = '0;
  logic [8:0]  cpat_idx = '0;
  logic [23:0] pal_rgb, cur_rgb;
  logic [15:0] cpat_word;
  logic [4:0]  depth_code;
  logic        blank_force, cursor_off;
  logic [31:0] screen_top, cursor_xy, width_px, height_px;

  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  fbctl_regs u_fbctl_regs (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rd(bus_rd), .bus_rdata(bus_rdata),
    .frame_done(frame_done), .irq(irq), .pal_idx(pal_idx), .pal_rgb(pal_rgb),
    .cur_sel(cur_sel), .cur_rgb(cur_rgb), .cpat_idx(cpat_idx), .cpat_word(cpat_word),
    .depth_code(depth_code), .blank_force(blank_force), .cursor_off(cursor_off),
    .screen_top(screen_top), .cursor_xy(cursor_xy), .width_px(width_px),
    .height_px(height_px)
  );

  // ---------------- behavioural reference model ----------------
  logic [31:0] m_clut [256];
  logic [31:0] m_curc [3];
  logic [31:0] m_cpat [512];
  logic [31:0] m_mode, m_top, m_cxy, m_w, m_h, m_rdata;
  logic        m_irq;

  function automatic logic [31:0] m_depth(input logic [31:0] mode);
    int lut [8] = '{1, 2, 4, 8, 15, 16, 0, 0};
    return 32'(lut[mode[22:20]]);
  endfunction

  task automatic m_clear();
    foreach (m_clut[i]) m_clut[i] = 0;
    foreach (m_curc[i]) m_curc[i] = 0;
    foreach (m_cpat[i]) m_cpat[i] = 0;
    m_mode = 0; m_top = 0; m_cxy = 0; m_w = 0; m_h = 0;
  endtask

  function automatic logic [31:0] m_read(input logic [20:0] a);
    int ai = int'(a);
    if (ai >= 'h1000 && ai < 'h2000) return m_cpat[(ai - 'h1000) / 8];
    if (ai >= 'h508 && ai < 'h520)   return m_curc[(ai - 'h508) / 8];
    if (ai == 'h118) return m_w >> 2;
    if (ai == 'h150) return m_h << 1;
    if (ai == 'h300) return m_mode;
    return 0;
  endfunction

  task automatic m_write(input logic [20:0] a, input logic [31:0] d);
    int ai = int'(a);
    if (ai >= 'h800 && ai < 'h1000)       m_clut[(ai - 'h800) / 8] = d & 32'hFF_FFFF;
    else if (ai >= 'h1000 && ai < 'h2000) m_cpat[(ai - 'h1000) / 8] = d & 32'hFFFF;
    else if (ai >= 'h508 && ai < 'h520)   m_curc[(ai - 'h508) / 8] = d & 32'hFF_FFFF;
    else if (ai == 'h118) m_w = d << 2;
    else if (ai == 'h150) m_h = d >> 1;
    else if (ai == 'h300) m_mode = d;
    else if (ai == 'h400) m_top = d;
    else if (ai == 'h638) m_cxy = d;
    else if (ai == 'h100000) m_clear();
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      m_clear(); m_rdata = 0; m_irq = 0;
    end else begin
      m_rdata = bus_rd ? m_read(bus_addr) : 0;
      if (bus_wr) m_irq = 0;
      else if (frame_done) m_irq = 1;
      if (bus_wr) m_write(bus_addr, bus_wdata);
    end
  end

  // ---------------- checking ----------------
  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h at %0t", req, what, act, exp, $time);
    end
  endtask

  task automatic check_all();
    chk("R10", "bus_rdata", bus_rdata, m_rdata);
    chk("R9", "irq", 32'(irq), 32'(m_irq));
    chk("R6", "depth_code", 32'(depth_code), m_depth(m_mode));
    chk("R6", "blank_force", 32'(blank_force), 32'(m_mode[10]));
    chk("R6", "cursor_off", 32'(cursor_off), 32'(m_mode[23]));
    chk("R7", "screen_top", screen_top, m_top);
    chk("R7", "cursor_xy", cursor_xy, m_cxy);
    chk("R4", "width_px", width_px, m_w);
    chk("R5", "height_px", height_px, m_h);
    chk("R1", "pal_rgb", 32'(pal_rgb), m_clut[pal_idx]);
    chk("R2", "cur_rgb", 32'(cur_rgb), (cur_sel < 3) ? m_curc[cur_sel] : 32'd0);
    chk("R3", "cpat_word", 32'(cpat_word), m_cpat[cpat_idx]);
  endtask

  task automatic tick();
    @(negedge clk);
    check_all();
  endtask

  task automatic wr(input logic [20:0] a, input logic [31:0] d);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    tick();
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [20:0] a, output logic [31:0] v);
    bus_rd = 1'b1; bus_addr = a;
    tick();
    bus_rd = 1'b0;
    v = bus_rdata;
  endtask

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
  endtask

  initial begin
    repeat (3000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=hung expected=done");
    summary();
    $finish;
  end

  logic [20:0] tlist [14] = '{21'h000, 21'h108, 21'h110, 21'h120, 21'h128, 21'h130, 21'h138,
                              21'h140, 21'h148, 21'h158, 21'h160, 21'h168, 21'h170, 21'h200};

  function automatic logic [20:0] pick_addr();
    case ($urandom % 11)
      0, 1: return 21'(32'h800 + ($urandom % 2048));
      2:    return 21'(32'h508 + ($urandom % 24));
      3, 4: return 21'(32'h1000 + ($urandom % 4096));
      5:    return 21'h118;
      6:    return 21'h150;
      7:    return ($urandom % 2) ? 21'h300 : 21'h400;
      8:    return ($urandom % 2) ? 21'h638 : tlist[$urandom % 14];
      9:    return ($urandom % 40 == 0) ? 21'h100000 : 21'($urandom);
      default: return tlist[$urandom % 14];
    endcase
  endfunction

  logic [31:0] v;

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    tick();
    // reset state (R8, R9, R10)
    chk("R9", "irq after reset", 32'(irq), 0);
    chk("R8", "width after reset", width_px, 0);
    chk("R6", "depth after reset", 32'(depth_code), 1);

    // R1 colour table and its bus read (R10)
    wr(21'h800 + 21'd40, 32'hFFA1_B2C3);
    pal_idx = 8'd5; #1;
    chk("R1", "pal entry 5", 32'(pal_rgb), 32'hA1_B2C3);
    rd(21'h828, v); chk("R10", "colour table read", v, 0);

    // R2 cursor colours
    wr(21'h510, 32'hFF11_2233);
    rd(21'h510, v); chk("R2", "cursor colour 1 read", v, 32'h0011_2233);
    cur_sel = 2'd1; #1; chk("R2", "cursor colour 1 lookup", 32'(cur_rgb), 32'h11_2233);
    cur_sel = 2'd3; #1; chk("R2", "cursor colour sel 3", 32'(cur_rgb), 0);

    // R3 cursor bitmap
    wr(21'h1000 + 21'd2400, 32'hDEAD_BEEF);
    rd(21'h1000 + 21'd2404, v); chk("R3", "bitmap 300 read", v, 32'h0000_BEEF);
    cpat_idx = 9'd300; #1; chk("R3", "bitmap 300 lookup", 32'(cpat_word), 32'hBEEF);

    // R4 / R5 scaling
    wr(21'h118, 32'd5);  chk("R4", "width", width_px, 32'd20);
    rd(21'h118, v);      chk("R4", "width read", v, 32'd5);
    wr(21'h150, 32'd7);  chk("R5", "height", height_px, 32'd3);
    rd(21'h150, v);      chk("R5", "height read", v, 32'd6);

    // R6 mode word
    wr(21'h300, 32'h00B0_0400);
    chk("R6", "depth 8", 32'(depth_code), 32'd8);
    chk("R6", "blank", 32'(blank_force), 1);
    chk("R6", "cursor off", 32'(cursor_off), 1);
    rd(21'h300, v); chk("R6", "mode read", v, 32'h00B0_0400);
    wr(21'h300, 32'h0060_0000); chk("R6", "depth sel 6", 32'(depth_code), 0);

    // R7 origin and cursor
    wr(21'h400, 32'h0001_2345); chk("R7", "origin", screen_top, 32'h0001_2345);
    wr(21'h638, 32'h0040_0080); chk("R7", "cursor xy", cursor_xy, 32'h0040_0080);
    rd(21'h400, v); chk("R7", "origin read", v, 0);

    // R9 interrupt, write wins over frame_done
    frame_done = 1'b1; tick(); frame_done = 1'b0;
    chk("R9", "irq raised", 32'(irq), 1);
    frame_done = 1'b1; wr(21'h108, 32'hFFFF_FFFF); frame_done = 1'b0;
    chk("R9", "write beats frame_done", 32'(irq), 0);

    // R11 timing offsets ignored
    foreach (tlist[i]) wr(tlist[i], 32'hFFFF_FFFF);
    chk("R11", "width kept", width_px, 32'd20);
    chk("R11", "origin kept", screen_top, 32'h0001_2345);
    rd(21'h300, v); chk("R11", "mode kept", v, 32'h0060_0000);

    // R10 read coincident with write returns old value
    bus_rd = 1'b1; wr(21'h118, 32'd9); bus_rd = 1'b0;
    chk("R10", "read-with-write old value", bus_rdata, 32'd5);
    tick(); chk("R10", "idle rdata", bus_rdata, 0);

    // R8 soft reset
    wr(21'h100000, 32'h0);
    chk("R8", "width cleared", width_px, 0);
    chk("R8", "origin cleared", screen_top, 0);
    pal_idx = 8'd5; cur_sel = 2'd1; cpat_idx = 9'd300; #1;
    chk("R8", "colour cleared", 32'(pal_rgb), 0);
    chk("R8", "cursor colour cleared", 32'(cur_rgb), 0);
    chk("R8", "bitmap cleared", 32'(cpat_word), 0);

    // random phase, compared against the model every clock
    for (int n = 0; n < 2500; n++) begin
      bus_addr   = pick_addr();
      bus_wdata  = $urandom;
      bus_wr     = ($urandom % 3) == 0;
      bus_rd     = ($urandom % 2) == 0;
      frame_done = ($urandom % 5) == 0;
      pal_idx    = 8'($urandom);
      cur_sel    = 2'($urandom);
      cpat_idx   = 9'($urandom);
      tick();
    end
    bus_wr = 1'b0; bus_rd = 1'b0; frame_done = 1'b0;
    tick();

    summary();
    $finish;
  end

endmodule